// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block keeps eight 80-bit data registers that software addresses relative to a rotating 3-bit top pointer. It takes a two-byte opcode and carries out one stack housekeeping operation per request. The operations are: exchange the top with another element, move the pointer up or down, push a copy of an element, push the constant zero or one, copy the top into an element and pop, and mark an element empty. Register contents are opaque 80-bit patterns. The block performs no arithmetic on them.

A request is taken on a cycle where `opValid` and `ready` are both high. The register file, the tag bits and the pointer update at that clock edge. `done` pulses during the following cycle, and the illegal, overflow and underflow flags are valid alongside it. A request that is illegal, or that would overflow or underflow the stack, reports its flag and changes no state. `stTopData` always shows the contents of the current top element, so software can observe the data.

Top module: `fpstk_top`

## Requirements
- R1: After reset, `topPtr` is 0, every tag bit is 0 (empty), `done` and all three flags are 0, and `ready` is 1.
- R2: A request is accepted when `opValid` and `ready` are both high. `done` is high for exactly one cycle, in the cycle after acceptance. `ready` is low during that cycle, and `opValid` is ignored while `ready` is low. The flags are high only while `done` is high.
- R3: The first byte must have its bits [7:3] equal to 11011, and the request must match one of the patterns listed in R5 to R10. Any other request raises `illegal` and leaves the pointer, tags and data unchanged.
- R4: Index i (the low three bits of the second byte) selects physical register (top + i) mod 8. `tagBits[p]` is 1 when physical register p holds a value and 0 when it is empty.
- R5: First byte 0xD9 with second byte 0xEE pushes +0.0, which is all 80 bits zero. First byte 0xD9 with second byte 0xE8 pushes +1.0, which is sign 0, exponent 0x3FFF and significand 0x8000000000000000. A push decrements the pointer mod 8, writes the new top and sets its tag.
- R6: First byte 0xD9 with second byte 11000iii pushes a copy of ST(i). The source is read before the pointer moves.
- R7: First byte 0xDD with second byte 11011iii copies ST(0) into ST(i), sets that tag, then pops. A pop clears the old top's tag and increments the pointer mod 8. With i = 0 the net effect is a pop only.
- R8: First byte 0xD9 with second byte 11001iii swaps the data of ST(0) and ST(i). Both tags stay set.
- R9: First byte 0xD9 with second byte 0xF7 increments the pointer mod 8, and second byte 0xF6 decrements it mod 8. Data and tags are unchanged.
- R10: First byte 0xDD with second byte 11000iii clears the tag of ST(i). The pointer and data are unchanged, and freeing an empty register raises no flag.
- R11: A push whose target register (top − 1) is already tagged raises `overflow` and changes nothing.
- R12: A request that reads an empty register raises `underflow` and changes nothing. This applies to an exchange with either operand empty, a copy-push from an empty ST(i), and a store-and-pop with an empty ST(0). Underflow is checked before overflow, so the two flags are never raised together.
- R13: `stTopData` equals the contents of physical register `topPtr` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Request strobe |
| opByte0 | input | 8 | First opcode byte |
| opByte1 | input | 8 | Second opcode byte |
| ready | output | 1 | Block can accept a request |
| done | output | 1 | One-cycle completion pulse |
| topPtr | output | 3 | Current top-of-stack pointer |
| tagBits | output | 8 | Per-physical-register valid bits |
| illegal | output | 1 | Request was not a supported opcode |
| overflow | output | 1 | Push target was occupied |
| underflow | output | 1 | An operand register was empty |
| stTopData | output | 80 | Contents of the current top register |

## Verification
The assertions assume that the opcode bytes are stable in any cycle where `opValid` is high. They also assume that a request is judged against the tag state at the cycle of acceptance. The stimulus sets inputs only on falling edges and holds them until the next falling edge, so each request is seen as a single steady value at its accepting edge. The sequence drives the stack from empty to full and back. It deliberately places requests at the wrap of the pointer, at index 7, and at the index-0 corner of store-and-pop. One request is held through the cycle where `ready` is low, which shows that it is taken only once.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  localparam int PTR_W = 3;
  localparam int DEPTH = 1 << PTR_W;

  typedef enum logic [1:0] {SRC_REG, SRC_ZERO, SRC_ONE} srcSel_e;
  typedef enum logic [1:0] {TOP_HOLD, TOP_INC, TOP_DEC} topMove_e;
  typedef enum logic [3:0] {
    OP_BAD, OP_XCH, OP_INC, OP_DEC, OP_LDI, OP_LDZ, OP_LD1, OP_STP, OP_FREE
  } opKind_e;

  typedef struct packed {
    logic             wrA;
    logic [PTR_W-1:0] idxA;
    srcSel_e          srcA;
    logic [PTR_W-1:0] srcIdx;
    logic             wrB;
    logic [PTR_W-1:0] idxB;
    logic             clrTag;
    logic [PTR_W-1:0] clrIdx;
    topMove_e         topMove;
  } stkStrobe_t;
endpackage

// File: rtl/fpstk_control.sv
module fpstk_control
  import fpstk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [7:0]       opByte0,
  input  logic [7:0]       opByte1,
  input  logic [PTR_W-1:0] topPtr,
  input  logic [DEPTH-1:0] tagBits,
  output stkStrobe_t       strobe,
  output logic             ready,
  output logic             done,
  output logic             illegal,
  output logic             overflow,
  output logic             underflow
);
  localparam logic [4:0] FP_PREFIX = 5'b11011;

  opKind_e          kind;
  logic [PTR_W-1:0] stIdx;
  logic [PTR_W-1:0] physI;
  logic [PTR_W-1:0] pushSlot;
  logic [4:0]       hiBits;
  logic             accept;
  logic             isUnder;
  logic             isOver;
  logic             isPush;
  logic             fire;

  assign stIdx    = opByte1[PTR_W-1:0];
  assign hiBits   = opByte1[7:3];
  assign physI    = topPtr + stIdx;
  assign pushSlot = topPtr - 1'b1;
  assign accept   = opValid && ready;
  assign ready    = !done;

  always_comb begin
    kind = OP_BAD;
    if (opByte0[7:3] == FP_PREFIX) begin
      case (opByte0[2:0])
        3'b001: begin
          if (hiBits == 5'b11001)      kind = OP_XCH;
          else if (opByte1 == 8'hF7)   kind = OP_INC;
          else if (opByte1 == 8'hF6)   kind = OP_DEC;
          else if (hiBits == 5'b11000) kind = OP_LDI;
          else if (opByte1 == 8'hEE)   kind = OP_LDZ;
          else if (opByte1 == 8'hE8)   kind = OP_LD1;
        end
        3'b101: begin
          if (hiBits == 5'b11011)      kind = OP_STP;
          else if (hiBits == 5'b11000) kind = OP_FREE;
        end
        default: kind = OP_BAD;
      endcase
    end
  end

  assign isPush  = (kind == OP_LDI) || (kind == OP_LDZ) || (kind == OP_LD1);
  assign isUnder = ((kind == OP_XCH) && (!tagBits[topPtr] || !tagBits[physI])) ||
                   ((kind == OP_LDI) && !tagBits[physI]) ||
                   ((kind == OP_STP) && !tagBits[topPtr]);
  assign isOver  = !isUnder && isPush && tagBits[pushSlot];
  assign fire    = accept && (kind != OP_BAD) && !isUnder && !isOver;

  always_comb begin
    strobe = '0;
    if (fire) begin
      case (kind)
        OP_XCH: begin
          strobe.wrA = 1'b1; strobe.idxA = topPtr; strobe.srcA = SRC_REG;
          strobe.srcIdx = physI;
          strobe.wrB = 1'b1; strobe.idxB = physI;
        end
        OP_INC: strobe.topMove = TOP_INC;
        OP_DEC: strobe.topMove = TOP_DEC;
        OP_LDI: begin
          strobe.wrA = 1'b1; strobe.idxA = pushSlot; strobe.srcA = SRC_REG;
          strobe.srcIdx = physI; strobe.topMove = TOP_DEC;
        end
        OP_LDZ: begin
          strobe.wrA = 1'b1; strobe.idxA = pushSlot; strobe.srcA = SRC_ZERO;
          strobe.topMove = TOP_DEC;
        end
        OP_LD1: begin
          strobe.wrA = 1'b1; strobe.idxA = pushSlot; strobe.srcA = SRC_ONE;
          strobe.topMove = TOP_DEC;
        end
        OP_STP: begin
          strobe.wrA = 1'b1; strobe.idxA = physI; strobe.srcA = SRC_REG;
          strobe.srcIdx = topPtr;
          strobe.clrTag = 1'b1; strobe.clrIdx = topPtr; strobe.topMove = TOP_INC;
        end
        OP_FREE: begin
          strobe.clrTag = 1'b1; strobe.clrIdx = physI;
        end
        default: strobe = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      illegal   <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      done      <= accept;
      illegal   <= accept && (kind == OP_BAD);
      overflow  <= accept && isOver;
      underflow <= accept && isUnder;
    end
  end

  // R2: completion is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R2: flags appear only together with done
  a_r2_flags_with_done: assert property (@(posedge clk) disable iff (!rstN)
    (illegal || overflow || underflow) |-> done);
  // R3: an illegal request leaves pointer and tags alone
  a_r3_illegal_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (accept && kind == OP_BAD) |=> ($stable(topPtr) && $stable(tagBits)));
  // R11: overflow suppresses the push
  a_r11_no_overflow_change: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isOver) |=> ($stable(topPtr) && $stable(tagBits)));
  // R12: underflow suppresses the request
  a_r12_no_underflow_change: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isUnder) |=> ($stable(topPtr) && $stable(tagBits)));
  // R12: the two stack faults never coincide
  a_r12_faults_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(overflow && underflow));
  // R9: increment moves only the pointer
  a_r9_inc_pointer: assert property (@(posedge clk) disable iff (!rstN)
    (fire && kind == OP_INC) |=>
      (topPtr == PTR_W'($past(topPtr) + 1'b1) && $stable(tagBits)));
  // R5: a good push lands on a tagged new top
  a_r5_push_tagged: assert property (@(posedge clk) disable iff (!rstN)
    (fire && isPush) |=> (tagBits[topPtr] && topPtr == $past(pushSlot)));
  // R7: store-and-pop empties the old top
  a_r7_pop_clears: assert property (@(posedge clk) disable iff (!rstN)
    (fire && kind == OP_STP) |=>
      (!tagBits[$past(topPtr)] && topPtr == PTR_W'($past(topPtr) + 1'b1)));
endmodule

// File: rtl/fpstk_datapath.sv
module fpstk_datapath
  import fpstk_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  localparam int DATA_W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  stkStrobe_t        strobe,
  output logic [PTR_W-1:0]  topPtr,
  output logic [DEPTH-1:0]  tagBits,
  output logic [DATA_W-1:0] stTopData
);
  localparam logic [EXP_W-1:0] EXP_BIAS = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] CONST_ZERO = '0;
  localparam logic [DATA_W-1:0] CONST_ONE =
    {1'b0, EXP_BIAS, 1'b1, {(MAN_W-1){1'b0}}};

  logic [DATA_W-1:0] regFile [DEPTH];
  logic [DATA_W-1:0] aVal;

  always_comb begin
    case (strobe.srcA)
      SRC_ZERO: aVal = CONST_ZERO;
      SRC_ONE:  aVal = CONST_ONE;
      default:  aVal = regFile[strobe.srcIdx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topPtr  <= '0;
      tagBits <= '0;
      for (int k = 0; k < DEPTH; k++) regFile[k] <= '0;
    end else begin
      if (strobe.wrA) begin
        regFile[strobe.idxA] <= aVal;
        tagBits[strobe.idxA] <= 1'b1;
      end
      if (strobe.wrB) begin
        regFile[strobe.idxB] <= regFile[strobe.idxA];
        tagBits[strobe.idxB] <= 1'b1;
      end
      if (strobe.clrTag) tagBits[strobe.clrIdx] <= 1'b0;
      case (strobe.topMove)
        TOP_INC: topPtr <= topPtr + 1'b1;
        TOP_DEC: topPtr <= topPtr - 1'b1;
        default: topPtr <= topPtr;
      endcase
    end
  end

  assign stTopData = regFile[topPtr];

  // R10: a freed register reads empty afterwards unless rewritten
  a_r10_free_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrTag && !strobe.wrA) |=> !tagBits[$past(strobe.clrIdx)]);
  // R8: exchange keeps the target register's old top value
  a_r8_swap_moves: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrB |=> (regFile[$past(strobe.idxB)] == $past(regFile[strobe.idxA])));
endmodule

// File: rtl/fpstk_top.sv
module fpstk_top
  import fpstk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [7:0]  opByte0,
  input  logic [7:0]  opByte1,
  output logic        ready,
  output logic        done,
  output logic [2:0]  topPtr,
  output logic [7:0]  tagBits,
  output logic        illegal,
  output logic        overflow,
  output logic        underflow,
  output logic [79:0] stTopData
);
  stkStrobe_t strobe;

  fpstk_control uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opByte0(opByte0),
    .opByte1(opByte1), .topPtr(topPtr), .tagBits(tagBits), .strobe(strobe),
    .ready(ready), .done(done), .illegal(illegal), .overflow(overflow),
    .underflow(underflow)
  );

  fpstk_datapath #(.EXP_W(15), .MAN_W(64)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .topPtr(topPtr),
    .tagBits(tagBits), .stTopData(stTopData)
  );
endmodule

// File: tb/fpstk_top_test.sv
`timescale 1ns/100ps
module fpstk_top_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, opValid = 1'b0;
  logic [7:0] opByte0 = 8'h00, opByte1 = 8'h00;
  logic ready, done, illegal, overflow, underflow;
  logic [2:0] topPtr;
  logic [7:0] tagBits;
  logic [79:0] stTopData;

  fpstk_top uut (.*);

  localparam logic [79:0] V_ZERO = 80'h0;
  localparam logic [79:0] V_ONE  = {1'b0, 15'h3FFF, 64'h8000000000000000};

  typedef struct {
    logic [2:0] top; logic [7:0] tags; logic [79:0] st;
    logic ill, ov, un; string lab;
  } exp_t;
  exp_t expQ[$];

  int checks = 0, errors = 0;
  logic [2:0]  mTop = 3'd0;
  logic [7:0]  mTag = 8'h00;
  logic [79:0] mData [8];
  initial for (int k = 0; k < 8; k++) mData[k] = '0;

  task automatic check(input bit ok, input string lab, input string act, input string expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s", lab, act, expv);
    end
  endtask

  task automatic modelOp(input logic [7:0] b0, input logic [7:0] b1,
                         output logic ill, output logic ov, output logic un);
    logic [2:0] p, pu;
    logic [79:0] t;
    ill = 0; ov = 0; un = 0;
    p = mTop + b1[2:0]; pu = mTop - 3'd1;
    if (b0[7:3] != 5'b11011) ill = 1;
    else if (b0[2:0] == 3'b001) begin
      if (b1[7:3] == 5'b11001) begin
        if (!mTag[mTop] || !mTag[p]) un = 1;
        else begin t = mData[mTop]; mData[mTop] = mData[p]; mData[p] = t; end
      end else if (b1 == 8'hF7) mTop = mTop + 3'd1;
      else if (b1 == 8'hF6) mTop = mTop - 3'd1;
      else if (b1[7:3] == 5'b11000) begin
        if (!mTag[p]) un = 1;
        else if (mTag[pu]) ov = 1;
        else begin mData[pu] = mData[p]; mTag[pu] = 1; mTop = pu; end
      end else if (b1 == 8'hEE || b1 == 8'hE8) begin
        if (mTag[pu]) ov = 1;
        else begin mData[pu] = (b1 == 8'hE8) ? V_ONE : V_ZERO; mTag[pu] = 1; mTop = pu; end
      end else ill = 1;
    end else if (b0[2:0] == 3'b101) begin
      if (b1[7:3] == 5'b11011) begin
        if (!mTag[mTop]) un = 1;
        else begin mData[p] = mData[mTop]; mTag[p] = 1; mTag[mTop] = 0; mTop = mTop + 3'd1; end
      end else if (b1[7:3] == 5'b11000) mTag[p] = 0;
      else ill = 1;
    end else ill = 1;
  endtask

  task automatic expectOp(input logic [7:0] b0, input logic [7:0] b1, input string lab);
    exp_t e;
    logic ill, ov, un;
    modelOp(b0, b1, ill, ov, un);
    e.top = mTop; e.tags = mTag; e.st = mData[mTop];
    e.ill = ill; e.ov = ov; e.un = un; e.lab = lab;
    expQ.push_back(e);
  endtask

  task automatic issue(input logic [7:0] b0, input logic [7:0] b1, input string lab);
    expectOp(b0, b1, lab);
    @(negedge clk); opValid = 1'b1; opByte0 = b0; opByte1 = b1;
    @(negedge clk); opValid = 1'b0;
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check(0, "R2 unexpected done", "done=1", "no done");
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(topPtr == e.top && tagBits == e.tags, {e.lab, " state"},
              $sformatf("top=%0d tags=%02h", topPtr, tagBits),
              $sformatf("top=%0d tags=%02h", e.top, e.tags));
        check(stTopData == e.st, {e.lab, " R13 top data"},
              $sformatf("%020h", stTopData), $sformatf("%020h", e.st));
        check({illegal, overflow, underflow} == {e.ill, e.ov, e.un}, {e.lab, " flags"},
              $sformatf("%b%b%b", illegal, overflow, underflow),
              $sformatf("%b%b%b", e.ill, e.ov, e.un));
        check(!ready, "R2 ready low with done", $sformatf("%b", ready), "0");
      end
    end else if (rstN) begin
      check(!(illegal || overflow || underflow), "R2 flags without done",
            $sformatf("%b%b%b", illegal, overflow, underflow), "000");
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    check(0, "watchdog", "timeout", "finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(topPtr == 0 && tagBits == 0, "R1 reset state",
          $sformatf("top=%0d tags=%02h", topPtr, tagBits), "top=0 tags=00");
    check(!done && ready && !illegal && !overflow && !underflow, "R1 reset handshake",
          $sformatf("d=%b r=%b", done, ready), "d=0 r=1");

    issue(8'hD9, 8'hF6, "R9 dec wrap");
    issue(8'hD9, 8'hF7, "R9 inc wrap");
    issue(8'hD9, 8'hE8, "R5 push one");
    issue(8'hD9, 8'hEE, "R5 push zero");
    issue(8'hD9, 8'hC9, "R8 exchange 1");
    issue(8'hD9, 8'hC1, "R6 copy ST1 / R4 index");
    issue(8'h59, 8'hE8, "R3 bad prefix");
    issue(8'hD8, 8'hC1, "R3 unsupported pattern");
    issue(8'hD9, 8'hD0, "R3 unsupported second byte");
    issue(8'hD9, 8'hCB, "R12 exchange empty");
    issue(8'hD9, 8'hC4, "R12 copy from empty");
    issue(8'hDD, 8'hDA, "R7 store ST2 pop");
    issue(8'hDD, 8'hC1, "R10 free ST1");
    issue(8'hDD, 8'hC3, "R10 free empty no flag");
    issue(8'hDD, 8'hD8, "R7 store ST0 pop");
    issue(8'hDD, 8'hD8, "R12 store from empty");

    issue(8'hD9, 8'hE8, "R5 fill one");
    for (int k = 0; k < 6; k++) issue(8'hD9, 8'hC0, "R6 fill copy");
    issue(8'hD9, 8'hEE, "R5 fill zero");
    issue(8'hD9, 8'hE8, "R11 push when full");
    issue(8'hD9, 8'hC7, "R11 copy ST7 when full");
    issue(8'hD9, 8'hCF, "R8 exchange ST7");
    issue(8'hDD, 8'hDF, "R7 store ST7 pop");
    issue(8'hD9, 8'hC7, "R6 copy ST7 empty target");

    // R2: request held through the ready-low cycle is taken once
    expectOp(8'hD9, 8'hF7, "R2 held request once");
    @(negedge clk); opValid = 1'b1; opByte0 = 8'hD9; opByte1 = 8'hF7;
    @(negedge clk);
    @(negedge clk); opValid = 1'b0;
    repeat (3) @(negedge clk);
    check(topPtr == mTop, "R2 held request top",
          $sformatf("%0d", topPtr), $sformatf("%0d", mTop));
    check(expQ.size() == 0, "R2 all results seen",
          $sformatf("%0d", expQ.size()), "0");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule